// File: doc/BRIEF.md
# Multi-Mode Memory Address Generator

This block forms the physical bus address that a DMA-style coprocessor drives for each memory access. Control structures (command blocks, descriptors and the shared control block) are located by adding a 16-bit per-structure offset to one shared base: the address of the system control block. Data buffers are located by plain linear pointers. Every request also carries a step value, so that sequential fetches inside one structure advance from its start.

A mode selector picks one of three schemes.
- In the narrow segmented mode every address is limited to 24 bits, and bits 31..24 are forced to zero.
- In the wide segmented mode offset and pointer sums use the full 32 bits.
- In the flat mode every request is treated as a linear pointer.

An offset that runs past the end of a 64 KiB segment carries into the next contiguous location. It does not wrap inside the segment.

A small two-state controller sequences the block.
- State `ST_IDLE` means no result is being presented.
- State `ST_EMIT` means the output register holds a fresh address.
- The transitions are: *accept* (ST_IDLE to ST_EMIT on a request), *stream* (ST_EMIT to ST_EMIT on a back-to-back request), *drain* (ST_EMIT to ST_IDLE when no request arrives) and *rest* (ST_IDLE to ST_IDLE).

The active mode register is reloaded from the mode input only on a cycle that carries no request.

Top module: `seg_addr_gen`

## Requirements
- R1: While reset is asserted and after its release, before any request, `addr_valid` is 0 and `addr_out` is 0, and the active mode is the narrow segmented mode (code 0).
- R2: A request sampled with `req_valid`=1 produces `addr_valid`=1 exactly one clock later, and requests may arrive on consecutive cycles. A cycle without a request gives `addr_valid`=0 one clock later.
- R3: In wide segmented mode (code 1), an offset request (`req_is_offset`=1) yields `cfg_base + req_offset + req_step` at full 32-bit width. A carry out of bit 15 propagates upward, with no wrap inside the segment.
- R4: In narrow segmented mode (code 0), every result has bits 31..24 equal to zero, whether it comes from an offset request or a pointer request.
- R5: In narrow segmented mode, an offset request yields `(cfg_base + req_offset + req_step) mod 2^24`.
- R6: In either segmented mode, a pointer request (`req_is_offset`=0) yields `req_ptr + req_step`. In narrow segmented mode this result is also masked as in R4.
- R7: In flat mode (code 2), `req_is_offset` is ignored and every request yields `(req_ptr + req_step) mod 2^32`.
- R8: The active mode is loaded from `cfg_mode` only on a clock edge where `req_valid`=0. A mode value presented together with a request has no effect on that request or on later ones until a request-free cycle occurs.
- R9: The mode code is 2 bits wide: 0 is narrow segmented, 1 is wide segmented, 2 is flat, and the unused code 3 behaves as flat.
- R10: When no request is taken, `addr_out` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Requested addressing mode (0 narrow segmented, 1 wide segmented, 2/3 flat) |
| cfg_base | input | 32 | Shared segment base (control block address) |
| req_valid | input | 1 | Access request strobe |
| req_is_offset | input | 1 | 1: request carries an offset, 0: request carries a linear pointer |
| req_ptr | input | 32 | Linear pointer |
| req_offset | input | 16 | Offset from the shared base |
| req_step | input | 16 | Increment for sequential fetches inside one structure |
| addr_valid | output | 1 | Address strobe, one cycle after the request |
| addr_out | output | 32 | Physical bus address |

## Verification
The two functions that can fall in the same cycle are accepting a request and reloading the addressing mode. The bench provokes this by changing `cfg_mode` on cycles where `req_valid` is high, both in directed sequences and at random. It judges the outcome with a reference model that loads its own mode copy only on request-free cycles. Every address produced after such a collision must match the old mode's arithmetic. The new mode must appear only after the first idle cycle, and this is checked again by a property that the active mode stays stable across any request cycle.

// File: rtl/seg_addr_gen_pkg.sv
package seg_addr_gen_pkg;

    typedef enum logic [1:0] {
        MODE_NARROW_SEG = 2'd0,
        MODE_WIDE_SEG   = 2'd1,
        MODE_FLAT       = 2'd2,
        MODE_FLAT_ALIAS = 2'd3
    } addr_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } gen_state_e;

    function automatic logic mode_has_segments(addr_mode_e m);
        return (m == MODE_NARROW_SEG) || (m == MODE_WIDE_SEG);
    endfunction

    function automatic logic mode_is_narrow(addr_mode_e m);
        return m == MODE_NARROW_SEG;
    endfunction

endpackage

// File: rtl/seg_addr_gen_ctrl.sv
module seg_addr_gen_ctrl
    import seg_addr_gen_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [1:0] cfg_mode,
    output addr_mode_e mode_q,
    output logic       capture,
    output logic       emit
);

    gen_state_e state_q;
    gen_state_e state_d;
    logic       mode_load;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: accept, stream, drain, rest
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = req_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs of the controller
    always_comb begin
        capture   = req_valid;
        mode_load = !req_valid;
        unique case (state_q)
            ST_IDLE: emit = 1'b0;
            ST_EMIT: emit = 1'b1;
            default: emit = 1'b0;
        endcase
    end

    // mode register: reloaded only while no request is pending
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_NARROW_SEG;
        end else if (mode_load) begin
            mode_q <= addr_mode_e'(cfg_mode);
        end
    end

endmodule

// File: rtl/seg_addr_gen_compose.sv
module seg_addr_gen_compose
    import seg_addr_gen_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int OFF_W    = 16,
    parameter int STEP_W   = 16,
    parameter int NARROW_W = 24
) (
    input  addr_mode_e        mode,
    input  logic [ADDR_W-1:0] base,
    input  logic              is_offset,
    input  logic [ADDR_W-1:0] ptr,
    input  logic [OFF_W-1:0]  offset,
    input  logic [STEP_W-1:0] step,
    output logic [ADDR_W-1:0] addr
);

    localparam logic [ADDR_W-1:0] NARROW_MASK = {ADDR_W{1'b1}} >> (ADDR_W - NARROW_W);

    logic              use_seg;
    logic [ADDR_W-1:0] origin;
    logic [ADDR_W-1:0] disp;
    logic [ADDR_W-1:0] full_sum;

    always_comb begin
        use_seg  = mode_has_segments(mode) && is_offset;
        origin   = use_seg ? (base + ADDR_W'(offset)) : ptr;
        disp     = ADDR_W'(step);
        full_sum = origin + disp;
    end

    generate
        if (NARROW_W < ADDR_W) begin : g_mask
            assign addr = mode_is_narrow(mode) ? (full_sum & NARROW_MASK) : full_sum;
        end else begin : g_nomask
            assign addr = full_sum;
        end
    endgenerate

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import seg_addr_gen_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int OFF_W    = 16,
    parameter int STEP_W   = 16,
    parameter int NARROW_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_mode,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic              req_valid,
    input  logic              req_is_offset,
    input  logic [ADDR_W-1:0] req_ptr,
    input  logic [OFF_W-1:0]  req_offset,
    input  logic [STEP_W-1:0] req_step,
    output logic              addr_valid,
    output logic [ADDR_W-1:0] addr_out
);

    addr_mode_e        mode_q;
    logic [1:0]        active_mode;
    logic              capture;
    logic              emit;
    logic [ADDR_W-1:0] next_addr;
    logic [ADDR_W-1:0] addr_q;

    assign active_mode = mode_q;

    seg_addr_gen_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .cfg_mode  (cfg_mode),
        .mode_q    (mode_q),
        .capture   (capture),
        .emit      (emit)
    );

    seg_addr_gen_compose #(
        .ADDR_W   (ADDR_W),
        .OFF_W    (OFF_W),
        .STEP_W   (STEP_W),
        .NARROW_W (NARROW_W)
    ) u_compose (
        .mode      (mode_q),
        .base      (cfg_base),
        .is_offset (req_is_offset),
        .ptr       (req_ptr),
        .offset    (req_offset),
        .step      (req_step),
        .addr      (next_addr)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (capture) begin
            addr_q <= next_addr;
        end
    end

    assign addr_out   = addr_q;
    assign addr_valid = emit;

endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk #(
    parameter int ADDR_W   = 32,
    parameter int OFF_W    = 16,
    parameter int STEP_W   = 16,
    parameter int NARROW_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode_q,
    input logic [ADDR_W-1:0] cfg_base,
    input logic              req_valid,
    input logic              req_is_offset,
    input logic [ADDR_W-1:0] req_ptr,
    input logic [OFF_W-1:0]  req_offset,
    input logic [STEP_W-1:0] req_step,
    input logic              addr_valid,
    input logic [ADDR_W-1:0] addr_out
);

    // R2
    a_r2_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> addr_valid);

    // R2
    a_r2_quiet_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !addr_valid);

    // R4
    a_r4_top_byte_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && mode_q == 2'd0) |-> (addr_out[ADDR_W-1:NARROW_W] == '0));

    // R8
    a_r8_mode_held_under_request: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> $stable(mode_q));

    // R10
    a_r10_addr_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(addr_out));

    // R3
    a_r3_wide_offset_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_is_offset && mode_q == 2'd1) |=>
        (addr_out == $past(cfg_base) + ADDR_W'($past(req_offset)) + ADDR_W'($past(req_step))));

    // R7
    a_r7_flat_pointer: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode_q[1]) |=>
        (addr_out == $past(req_ptr) + ADDR_W'($past(req_step))));

endmodule

bind seg_addr_gen seg_addr_gen_chk #(
    .ADDR_W   (ADDR_W),
    .OFF_W    (OFF_W),
    .STEP_W   (STEP_W),
    .NARROW_W (NARROW_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_q        (active_mode),
    .cfg_base      (cfg_base),
    .req_valid     (req_valid),
    .req_is_offset (req_is_offset),
    .req_ptr       (req_ptr),
    .req_offset    (req_offset),
    .req_step      (req_step),
    .addr_valid    (addr_valid),
    .addr_out      (addr_out)
);

// File: tb/test_seg_addr_gen.sv
`timescale 1ns/1ps
module test_seg_addr_gen;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  cfg_mode;
    logic [31:0] cfg_base;
    logic        req_valid;
    logic        req_is_offset;
    logic [31:0] req_ptr;
    logic [15:0] req_offset;
    logic [15:0] req_step;
    logic        addr_valid;
    logic [31:0] addr_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [1:0]  mdl_mode;
    logic [31:0] exp_addr;
    logic        exp_valid;

    always #10 clk = ~clk;

    seg_addr_gen i_seg_addr_gen (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_mode      (cfg_mode),
        .cfg_base      (cfg_base),
        .req_valid     (req_valid),
        .req_is_offset (req_is_offset),
        .req_ptr       (req_ptr),
        .req_offset    (req_offset),
        .req_step      (req_step),
        .addr_valid    (addr_valid),
        .addr_out      (addr_out)
    );

    function automatic logic [31:0] ref_addr(logic [1:0] m, logic [31:0] b, logic off_flag,
                                             logic [31:0] p, logic [15:0] o, logic [15:0] s);
        logic [31:0] r;
        if ((m == 2'd0 || m == 2'd1) && off_flag) r = b + {16'h0, o} + {16'h0, s};
        else                                      r = p + {16'h0, s};
        if (m == 2'd0) r[31:24] = 8'h00;
        return r;
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drives one cycle from a negedge and checks the result at the following negedge
    task automatic step(bit v, bit off_flag, logic [1:0] m, logic [31:0] b,
                        logic [31:0] p, logic [15:0] o, logic [15:0] s, string tag);
        string t;
        logic [31:0] nxt;
        req_valid = v; req_is_offset = off_flag; cfg_mode = m; cfg_base = b;
        req_ptr = p; req_offset = o; req_step = s;
        nxt = ref_addr(mdl_mode, b, off_flag, p, o, s);
        if (tag != "") t = tag;
        else if (!v) t = "R10";
        else if (mdl_mode[1]) t = "R7";
        else if (!off_flag) t = "R6";
        else if (mdl_mode == 2'd1) t = "R3";
        else t = "R5";
        @(posedge clk);
        if (v) exp_addr = nxt;
        exp_valid = v;
        if (!v) mdl_mode = m;
        @(negedge clk);
        chk(addr_valid == exp_valid, "R2", {31'h0, addr_valid}, {31'h0, exp_valid});
        chk(addr_out == exp_addr, t, addr_out, exp_addr);
        if (v && mdl_mode == 2'd0)
            chk(addr_out[31:24] == 8'h00, "R4", addr_out, exp_addr);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0; req_valid = 1'b0; req_is_offset = 1'b0; cfg_mode = 2'd1;
        cfg_base = 32'h0; req_ptr = 32'h0; req_offset = 16'h0; req_step = 16'h0;
        mdl_mode = 2'd0; exp_addr = 32'h0; exp_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(addr_valid == 1'b0, "R1", {31'h0, addr_valid}, 32'h0);
        chk(addr_out == 32'h0, "R1", addr_out, 32'h0);
        rst_n = 1'b1;
        // R1: after reset the narrow mode is active (request before any idle cycle)
        step(1, 1, 2'd2, 32'h12FF_FFF0, 32'h0, 16'h0020, 16'h0000, "R1");
        // R3: carry past the end of a segment into the next location
        step(0, 0, 2'd1, 32'h0, 32'h0, 16'h0, 16'h0, "");
        step(1, 1, 2'd1, 32'h0001_FFF0, 32'h0, 16'hFFF8, 16'h0010, "R3");
        step(1, 1, 2'd1, 32'hFFFF_FFFF, 32'h0, 16'h0001, 16'h0000, "R3");
        // R6: pointer request in wide mode
        step(1, 0, 2'd1, 32'h5555_0000, 32'h8000_0001, 16'h1234, 16'h0003, "R6");
        // R5/R4: narrow mode
        step(0, 0, 2'd0, 32'h0, 32'h0, 16'h0, 16'h0, "");
        step(1, 1, 2'd0, 32'hABFF_FFF0, 32'h0, 16'h0020, 16'h0000, "R5");
        step(1, 0, 2'd0, 32'h0, 32'hDEAD_BEEF, 16'h0, 16'h0001, "R4");
        // R9: unused code behaves as flat
        step(0, 0, 2'd3, 32'h0, 32'h0, 16'h0, 16'h0, "");
        step(1, 1, 2'd3, 32'h1000_0000, 32'hFFFF_FFFF, 16'h0100, 16'h0002, "R9");
        // R7: flat mode ignores the offset flag
        step(0, 0, 2'd2, 32'h0, 32'h0, 16'h0, 16'h0, "");
        step(1, 1, 2'd2, 32'h1000_0000, 32'hFF00_0010, 16'h0100, 16'h0004, "R7");
        // R8: mode change under a request is ignored
        step(1, 1, 2'd1, 32'h2000_0000, 32'h0000_0040, 16'h0300, 16'h0000, "R8");
        step(1, 1, 2'd1, 32'h2000_0000, 32'h0000_0080, 16'h0300, 16'h0000, "R8");
        step(0, 1, 2'd1, 32'h2000_0000, 32'h0000_0080, 16'h0300, 16'h0000, "R10");
        step(1, 1, 2'd1, 32'h2000_0000, 32'h0000_0080, 16'h0300, 16'h0000, "R8");
        step(0, 0, 2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 16'hFFFF, "R10");
        step(0, 1, 2'd2, 32'h0, 32'h0, 16'h0, 16'h0, "R10");
        // constrained random mix
        for (int i = 0; i < 3000; i++) begin
            bit          v;
            bit          f;
            logic [1:0]  m;
            logic [15:0] s;
            v = ($urandom % 4) != 0;
            f = $urandom % 2;
            m = (($urandom % 5) == 0) ? 2'($urandom % 4) : mdl_mode;
            s = (($urandom % 2) == 0) ? 16'($urandom % 64) : 16'($urandom);
            step(v, f, m, $urandom, $urandom, 16'($urandom), s, "");
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule